// File: doc/BRIEF.md
# Instruction Trace Control Unit

This block owns the two status bits that implement instruction tracing: a trace-enable bit (T) and a trace-pending bit (TP). It watches instruction boundaries. At each accepted instruction start it decides whether a trace fault must be taken first. It then arms TP from T for the instruction that goes on to run. The block guarantees that each traced instruction is traced exactly once, even when faults, aborts, arithmetic traps, interrupts, mode changes, exception returns and calls are mixed in.

Whenever the surrounding pipeline saves a status word, the block supplies the T and TP values for that word. It follows the save rule of each event class. Completion of an instruction is reported as one of five kinds. Decode flags arrive with a normal completion and mark change-mode, return-from-exception (with the restored T/TP), set-status-bits and call instructions. A separate load port lets software write T directly.

The sequencer has two states. IDLE means the unit is between instructions; EXEC means an instruction is running. The transitions are as follows:
- IDLE to EXEC: an accepted start with TP clear.
- IDLE to IDLE: a trace hit (an accepted start with TP set), or an interrupt taken between instructions.
- EXEC to IDLE: any completion.

Top module: `trace_ctl_top`

## Requirements
- R1: After reset (active-low `rst_n`), T and TP are 0, the unit is in IDLE, and neither `o_trace_req` nor `o_save_vld` is asserted.
- R2: An accepted start in IDLE with TP set raises `o_trace_req` in the same cycle and clears TP. The instruction does not begin and the unit stays in IDLE. One cycle later a save word is produced with T equal to live T and TP = 0.
- R3: An accepted start in IDLE with TP clear raises no trace request, copies the current T into TP and enters EXEC.
- R4: A completion of kind FAULT (code 1) or mid-instruction INTR (code 4) clears live TP. One cycle later it produces a save word with T equal to live T and TP = 0.
- R5: A completion of kind ABORT (code 2) or ATRAP (code 3) leaves T and TP unchanged and saves them unchanged. An interrupt between instructions (`i_intr_between` in IDLE) also saves the live T and TP unchanged. That interrupt takes priority over a start in the same cycle, which is dropped.
- R6: A NORMAL completion (code 0) with `i_dec_chm` clears live T and TP. It saves T and TP both equal to the T held before the instruction.
- R7: A NORMAL completion with `i_dec_rei` loads live T from `i_rest_t`. It sets TP to the old live T OR `i_rest_tp`, and produces no save word. A trace that follows is saved with the restored T.
- R8: A NORMAL completion with `i_dec_setbits` and `i_setbits_t` set turns T on. The first trace request then occurs at the second start after that instruction.
- R9: A NORMAL completion with `i_dec_call` saves T = 0 and TP equal to live TP, and leaves live T and TP unchanged.
- R10: `i_ld_t_en` writes `i_ld_t_val` into T in any cycle. A change-mode, return or set-status-bits completion in the same cycle overrides the write.
- R11: A start while in EXEC is ignored, and a completion while in IDLE is ignored: no trace request, no bit change, no save.
- R12: With T held set over a run of instructions, exactly one trace request is raised for each instruction after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Instruction start strobe |
| i_end | input | 1 | Instruction completion strobe |
| i_end_kind | input | 3 | Completion kind: 0 NORMAL, 1 FAULT, 2 ABORT, 3 ATRAP, 4 INTR |
| i_dec_chm | input | 1 | Completed instruction is a change-mode |
| i_dec_rei | input | 1 | Completed instruction is a return-from-exception |
| i_dec_setbits | input | 1 | Completed instruction is a set-status-bits |
| i_setbits_t | input | 1 | Set-status-bits mask includes T |
| i_dec_call | input | 1 | Completed instruction is a call |
| i_rest_t | input | 1 | T bit of the restored status word |
| i_rest_tp | input | 1 | TP bit of the restored status word |
| i_intr_between | input | 1 | Interrupt taken between instructions |
| i_ld_t_en | input | 1 | Software write enable for T |
| i_ld_t_val | input | 1 | Software write value for T |
| o_trace_req | output | 1 | Trace fault request, one cycle, aligned with the start |
| o_t | output | 1 | Live trace-enable bit |
| o_tp | output | 1 | Live trace-pending bit |
| o_save_vld | output | 1 | A status word is being saved |
| o_save_t | output | 1 | T value for the saved word |
| o_save_tp | output | 1 | TP value for the saved word |

## Verification
Some rules can be checked on every cycle, and the assertions do so. These are the per-event update rules:
- TP cleared after a trace hit (R2);
- TP armed from T at a clean start (R3);
- save values for faults, aborts, traps and calls (R4, R5, R9);
- clearing on change-mode (R6);
- the restore arithmetic of a return (R7);
- a busy unit ignoring a start (R11).

Other behaviours span several instructions, and only the bench's scenarios can show them. These are:
- the delayed first trace after a set-status-bits;
- the trace that follows a return being saved with the restored T;
- a dropped start when an interrupt wins;
- the exact pulse count over a traced run (R8, R7, R5, R12).

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        END_OK    = 3'd0,
        END_FAULT = 3'd1,
        END_ABORT = 3'd2,
        END_ATRAP = 3'd3,
        END_INTR  = 3'd4
    } end_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic t;
        logic tp;
    } trc_pair_t;

endpackage

// File: rtl/trace_seq.sv
module trace_seq
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       end_ev,
    input  logic       intr_btw,
    input  logic       tp,
    output logic       start_ok,
    output logic       trace_hit,
    output logic       end_ok,
    output logic       intr_ok,
    output seq_state_e state
);

    seq_state_e state_nxt;
    logic       idle;
    logic       begin_exec;

    assign idle = (state == ST_IDLE);

    always_comb begin
        intr_ok    = idle & intr_btw;
        start_ok   = idle & start & ~intr_btw;
        trace_hit  = start_ok & tp;
        begin_exec = start_ok & ~tp;
        end_ok     = ~idle & end_ev;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (begin_exec) state_nxt = ST_EXEC;
            ST_EXEC: if (end_ok)     state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // R2: a trace hit never starts the instruction
    a_r2_hit_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        trace_hit |=> (state == ST_IDLE));

    // R11: a start while busy keeps the unit busy
    a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && start && !end_ev) |=> (state == ST_EXEC));

endmodule

// File: rtl/trace_bits.sv
module trace_bits
    import trace_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_ok,
    input  logic      trace_hit,
    input  logic      end_ok,
    input  end_kind_e kind,
    input  logic      dec_chm,
    input  logic      dec_rei,
    input  logic      dec_setbits,
    input  logic      setbits_t,
    input  logic      rest_t,
    input  logic      rest_tp,
    input  logic      ld_en,
    input  logic      ld_val,
    output trc_pair_t bits
);

    trc_pair_t nxt;

    always_comb begin
        nxt = bits;
        if (ld_en) nxt.t = ld_val;
        if (start_ok) begin
            if (bits.tp) nxt.tp = 1'b0;
            else         nxt.tp = bits.t;
        end
        if (end_ok) begin
            unique case (kind)
                END_FAULT, END_INTR: nxt.tp = 1'b0;
                END_ABORT, END_ATRAP: ;
                END_OK: begin
                    if (dec_chm) begin
                        nxt.t  = 1'b0;
                        nxt.tp = 1'b0;
                    end else if (dec_rei) begin
                        nxt.t  = rest_t;
                        nxt.tp = bits.t | rest_tp;
                    end else if (dec_setbits && setbits_t) begin
                        nxt.t = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= nxt;
    end

    // R2: pending trace consumed
    a_r2_tp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        trace_hit |=> !bits.tp);

    // R3: pending armed from enable at a clean start
    a_r3_tp_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && !bits.tp) |=> (bits.tp == $past(bits.t)));

    // R6: change-mode clears both live bits
    a_r6_chm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && kind == END_OK && dec_chm) |=> (!bits.t && !bits.tp));

    // R7: return restores T and merges TP
    a_r7_rei_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && kind == END_OK && dec_rei && !dec_chm) |=>
        (bits.t == $past(rest_t)) && (bits.tp == ($past(bits.t) | $past(rest_tp))));

endmodule

// File: rtl/trace_save.sv
module trace_save
    import trace_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trc_pair_t bits,
    input  logic      trace_hit,
    input  logic      intr_ok,
    input  logic      end_ok,
    input  end_kind_e kind,
    input  logic      dec_chm,
    input  logic      dec_rei,
    input  logic      dec_setbits,
    input  logic      dec_call,
    output logic      sv_vld,
    output trc_pair_t sv
);

    logic      vld_nxt;
    trc_pair_t sv_nxt;

    always_comb begin
        vld_nxt = 1'b0;
        sv_nxt  = bits;
        if (trace_hit) begin
            vld_nxt   = 1'b1;
            sv_nxt.tp = 1'b0;
        end else if (intr_ok) begin
            vld_nxt = 1'b1;
        end else if (end_ok) begin
            unique case (kind)
                END_FAULT, END_INTR: begin
                    vld_nxt   = 1'b1;
                    sv_nxt.tp = 1'b0;
                end
                END_ABORT, END_ATRAP: vld_nxt = 1'b1;
                END_OK: begin
                    if (dec_chm) begin
                        vld_nxt   = 1'b1;
                        sv_nxt.tp = bits.t;
                    end else if (!dec_rei && !dec_setbits && dec_call) begin
                        vld_nxt  = 1'b1;
                        sv_nxt.t = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_vld <= 1'b0;
            sv     <= '0;
        end else begin
            sv_vld <= vld_nxt;
            sv     <= sv_nxt;
        end
    end

    // R4: fault or mid-instruction interrupt saves TP as clear
    a_r4_fault_save: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && (kind == END_FAULT || kind == END_INTR)) |=>
        (sv_vld && !sv.tp && sv.t == $past(bits.t)));

    // R5: abort or arithmetic trap saves TP untouched
    a_r5_trap_save: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && (kind == END_ABORT || kind == END_ATRAP)) |=>
        (sv_vld && sv.tp == $past(bits.tp)));

    // R9: call saves a clear T
    a_r9_call_save: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok && kind == END_OK && dec_call && !dec_chm && !dec_rei && !dec_setbits) |=>
        (sv_vld && !sv.t && sv.tp == $past(bits.tp)));

endmodule

// File: rtl/trace_ctl_top.sv
module trace_ctl_top
    import trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_start,
    input  logic              i_end,
    input  logic [KIND_W-1:0] i_end_kind,
    input  logic              i_dec_chm,
    input  logic              i_dec_rei,
    input  logic              i_dec_setbits,
    input  logic              i_setbits_t,
    input  logic              i_dec_call,
    input  logic              i_rest_t,
    input  logic              i_rest_tp,
    input  logic              i_intr_between,
    input  logic              i_ld_t_en,
    input  logic              i_ld_t_val,
    output logic              o_trace_req,
    output logic              o_t,
    output logic              o_tp,
    output logic              o_save_vld,
    output logic              o_save_t,
    output logic              o_save_tp
);

    end_kind_e  kind;
    trc_pair_t  bits;
    trc_pair_t  sv;
    seq_state_e state;
    logic       start_ok;
    logic       trace_hit;
    logic       end_ok;
    logic       intr_ok;

    assign kind = end_kind_e'(i_end_kind);

    trace_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (i_start),
        .end_ev    (i_end),
        .intr_btw  (i_intr_between),
        .tp        (bits.tp),
        .start_ok  (start_ok),
        .trace_hit (trace_hit),
        .end_ok    (end_ok),
        .intr_ok   (intr_ok),
        .state     (state)
    );

    trace_bits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok    (start_ok),
        .trace_hit   (trace_hit),
        .end_ok      (end_ok),
        .kind        (kind),
        .dec_chm     (i_dec_chm),
        .dec_rei     (i_dec_rei),
        .dec_setbits (i_dec_setbits),
        .setbits_t   (i_setbits_t),
        .rest_t      (i_rest_t),
        .rest_tp     (i_rest_tp),
        .ld_en       (i_ld_t_en),
        .ld_val      (i_ld_t_val),
        .bits        (bits)
    );

    trace_save u_save (
        .clk         (clk),
        .rst_n       (rst_n),
        .bits        (bits),
        .trace_hit   (trace_hit),
        .intr_ok     (intr_ok),
        .end_ok      (end_ok),
        .kind        (kind),
        .dec_chm     (i_dec_chm),
        .dec_rei     (i_dec_rei),
        .dec_setbits (i_dec_setbits),
        .dec_call    (i_dec_call),
        .sv_vld      (o_save_vld),
        .sv          (sv)
    );

    always_comb begin
        o_trace_req = trace_hit;
        o_t         = bits.t;
        o_tp        = bits.tp;
        o_save_t    = sv.t;
        o_save_tp   = sv.tp;
    end

    // R1: the trace request only ever appears between instructions
    a_r1_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        o_trace_req |-> (state == ST_IDLE && i_start));

endmodule

// File: tb/sim_trace_ctl_top.sv
`timescale 1ns/1ps
module sim_trace_ctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_start = 0, i_end = 0;
    logic [2:0] i_end_kind = 0;
    logic       i_dec_chm = 0, i_dec_rei = 0, i_dec_setbits = 0, i_setbits_t = 0, i_dec_call = 0;
    logic       i_rest_t = 0, i_rest_tp = 0, i_intr_between = 0, i_ld_t_en = 0, i_ld_t_val = 0;
    logic       o_trace_req, o_t, o_tp, o_save_vld, o_save_t, o_save_tp;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    trace_ctl_top u0 (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_end(i_end), .i_end_kind(i_end_kind),
        .i_dec_chm(i_dec_chm), .i_dec_rei(i_dec_rei), .i_dec_setbits(i_dec_setbits),
        .i_setbits_t(i_setbits_t), .i_dec_call(i_dec_call), .i_rest_t(i_rest_t),
        .i_rest_tp(i_rest_tp), .i_intr_between(i_intr_between), .i_ld_t_en(i_ld_t_en),
        .i_ld_t_val(i_ld_t_val), .o_trace_req(o_trace_req), .o_t(o_t), .o_tp(o_tp),
        .o_save_vld(o_save_vld), .o_save_t(o_save_t), .o_save_tp(o_save_tp)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_save(logic t, logic tp, string tag);
        exp_q.push_back({t, tp});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && o_save_vld) begin
            if (exp_q.size() == 0) begin
                chk("unexpected save word (R11)", 1, 0);
            end else begin
                logic [1:0] e;
                string      g;
                e = exp_q.pop_front();
                g = tag_q.pop_front();
                chk({g, " save word {t,tp}"}, {o_save_t, o_save_tp}, e);
            end
        end
    end

    task automatic do_start(logic exp_trc, string tag);
        i_start = 1;
        #1 chk({tag, " trace request"}, o_trace_req, exp_trc);
        @(negedge clk);
        i_start = 0;
    endtask

    task automatic do_end(logic [2:0] kind, logic chm, logic rei, logic bis, logic bist,
                          logic call, logic rt, logic rtp, logic ld, logic ldv);
        i_end = 1; i_end_kind = kind; i_dec_chm = chm; i_dec_rei = rei;
        i_dec_setbits = bis; i_setbits_t = bist; i_dec_call = call;
        i_rest_t = rt; i_rest_tp = rtp; i_ld_t_en = ld; i_ld_t_val = ldv;
        @(negedge clk);
        i_end = 0; i_end_kind = 0; i_dec_chm = 0; i_dec_rei = 0; i_dec_setbits = 0;
        i_setbits_t = 0; i_dec_call = 0; i_rest_t = 0; i_rest_tp = 0; i_ld_t_en = 0; i_ld_t_val = 0;
    endtask

    task automatic plain_end();
        do_end(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic write_t(logic v);
        i_ld_t_en = 1; i_ld_t_val = v;
        @(negedge clk);
        i_ld_t_en = 0; i_ld_t_val = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int pulses;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 t", o_t, 0); chk("R1 tp", o_tp, 0);
        chk("R1 req", o_trace_req, 0); chk("R1 save", o_save_vld, 0);
        rst_n = 1;
        @(negedge clk);

        // untraced instruction
        do_start(0, "R3 t0"); chk("R3 tp stays 0", o_tp, 0); plain_end();

        // R10 load port
        write_t(1); chk("R10 t written", o_t, 1); chk("R10 tp untouched", o_tp, 0);

        // R3 arming
        do_start(0, "R3 arm"); chk("R3 tp armed", o_tp, 1); plain_end();

        // R2 trace hit, then the real start; R4 fault
        expect_save(1, 0, "R2");
        do_start(1, "R2 hit"); chk("R2 tp cleared", o_tp, 0);
        do_start(0, "R2 restart"); chk("R3 tp rearmed", o_tp, 1);
        expect_save(1, 0, "R4 fault");
        do_end(3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R4 fault tp", o_tp, 0);

        // R4 mid-instruction interrupt
        do_start(0, "R4 pre"); chk("R4 armed", o_tp, 1);
        expect_save(1, 0, "R4 intr");
        do_end(3'd4, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R4 intr tp", o_tp, 0);

        // R5 abort and arithmetic trap
        do_start(0, "R5 pre");
        expect_save(1, 1, "R5 abort");
        do_end(3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R5 abort tp kept", o_tp, 1);
        expect_save(1, 0, "R2 after abort");
        do_start(1, "R2 after abort");
        do_start(0, "R5 pre2");
        expect_save(1, 1, "R5 atrap");
        do_end(3'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R5 atrap tp kept", o_tp, 1);

        // R5 interrupt between instructions wins over a start
        expect_save(1, 1, "R5 intr between");
        i_intr_between = 1;
        do_start(0, "R5 start dropped");
        i_intr_between = 0;
        chk("R5 tp kept", o_tp, 1);
        expect_save(1, 0, "R2 post intr");
        do_start(1, "R5 deferred hit");

        // R11 completion in idle ignored, start in exec ignored
        do_end(3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk("R11 idle end ignored tp", o_tp, 0);
        do_start(0, "R11 pre"); chk("R11 armed", o_tp, 1);
        do_start(0, "R11 busy start"); chk("R11 tp kept", o_tp, 1);

        // R6 change mode
        expect_save(1, 1, "R6 chm");
        do_end(3'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 t", o_t, 0); chk("R6 tp", o_tp, 0);

        // R7 return: restored T, TP from restored word
        do_start(0, "R7 a");
        do_end(3'd0, 0, 1, 0, 0, 0, 1, 0, 0, 0);
        chk("R7 t restored", o_t, 1); chk("R7 tp", o_tp, 0);
        do_start(0, "R7 b");
        do_end(3'd0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 t restored 0", o_t, 0); chk("R7 tp from old t", o_tp, 1);
        expect_save(0, 0, "R7 trace uses restored t");
        do_start(1, "R7 hit");
        do_start(0, "R7 c"); plain_end();
        do_start(0, "R7 d");
        do_end(3'd0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        chk("R7 tp from restored", o_tp, 1);
        expect_save(0, 0, "R7 hit2");
        do_start(1, "R7 hit2");
        do_start(0, "R7 e"); plain_end();

        // R8 set-status-bits
        do_start(0, "R8 bis");
        do_end(3'd0, 0, 0, 1, 1, 0, 0, 0, 0, 0); chk("R8 t on", o_t, 1);
        do_start(0, "R8 first after"); plain_end();
        expect_save(1, 0, "R8");
        do_start(1, "R8 second after");
        do_start(0, "R8 run");

        // R9 call
        expect_save(0, 1, "R9 call");
        do_end(3'd0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R9 t kept", o_t, 1); chk("R9 tp kept", o_tp, 1);

        // R10 collision: change mode beats load port
        expect_save(1, 0, "R2 pre collision");
        do_start(1, "R10 hit");
        do_start(0, "R10 pre");
        expect_save(1, 1, "R10 chm");
        do_end(3'd0, 1, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R10 chm wins", o_t, 0);

        // R12 traced run counts pulses
        write_t(1);
        pulses = 0;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) begin
                expect_save(1, 0, "R12");
                pulses++;
                do_start(1, "R12 hit");
            end
            do_start(0, "R12 run");
            plain_end();
        end
        chk("R12 pulse count", pulses, 4);

        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule